// File: doc/BRIEF.md
# Sprite Attribute Memory Block Copier

This block copies a fixed-size block of bytes into sprite attribute memory whenever the processor writes one trigger register. The byte written to that register chooses the source page. The source address is that byte followed by a zero low byte, so every source block starts on a 256-byte boundary. The block then acts as a bus master. It reads one source byte and writes it into sprite memory in the same cycle, at the matching offset from a fixed destination base.

A register write from the processor side drives the block through a strobe, an address and a data byte. The block shows it is running with `busy` and raises `done` for one cycle when the copy is complete. Writing the trigger register again while a copy is running abandons that copy. A new copy starts from offset zero using the new page. The read port assumes the bus returns `rd_data` in the same cycle as the address. The system must keep the processor off the bus while `busy` is high.

Top module: `oam_dma`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `rd_en` and `oam_we` are 0.
- R2: A cycle with `reg_wr`=1 and `reg_addr`=16'hFF46 starts a copy. On the next cycle `busy` is 1 and `rd_addr` is {`reg_wdata`, 8'h00}.
- R3: A write to any other address, or 16'hFF46 presented with `reg_wr`=0, leaves `busy` at 0 and causes no sprite-memory write.
- R4: A copy writes exactly 160 bytes to 16'hFE00 through 16'hFE9F, one per cycle in rising order. Each destination byte at offset k equals the source byte at {page, k}.
- R5: `busy` stays high for exactly 160 consecutive cycles per copy.
- R6: `done` is high for exactly one cycle, the cycle after the final write, and `busy` is 0 in that cycle.
- R7: A trigger write while `busy` is high restarts the copy at offset 0 with the new page. The restarted copy again lasts 160 cycles, and only one `done` pulse follows.
- R8: `rd_en` and `oam_we` equal `busy`, and `oam_wdata` equals `rd_data` whenever `oam_we` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Processor register write strobe |
| reg_addr | input | 16 | Processor write address |
| reg_wdata | input | 8 | Processor write data; source page on a trigger |
| rd_en | output | 1 | Source read request |
| rd_addr | output | 16 | Source read address |
| rd_data | input | 8 | Source read data, valid in the same cycle |
| oam_we | output | 1 | Sprite memory write enable |
| oam_addr | output | 16 | Sprite memory write address |
| oam_wdata | output | 8 | Sprite memory write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The assertions check the following on every cycle:
- a trigger loads the page and offset zero;
- an idle engine stays idle without a trigger;
- the source address steps by one;
- the destination address tracks the source offset;
- the done pulse follows the last offset and lasts one cycle;
- the write strobe and data mirror busy and the read data.

Some behaviour depends on the whole run, and only the bench scenarios can show it. This covers the full 160-byte contents landing at the right offsets for several pages, the exact busy length, and that nothing outside the destination window is written. It also covers the total write count and single done pulse when a copy is restarted partway through.

// File: rtl/oam_dma.sv
module oam_dma #(
  parameter int          LEN       = 160,
  parameter logic [15:0] TRIG_ADDR = 16'hFF46,
  parameter logic [15:0] DEST_BASE = 16'hFE00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic        rd_en,
  output logic [15:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        oam_we,
  output logic [15:0] oam_addr,
  output logic [7:0]  oam_wdata,
  output logic        busy,
  output logic        done
);
  localparam int IW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  logic [IW-1:0] idx;
  logic [7:0]    page;
  logic [7:0]    offs;
  logic          run;
  logic          fin;
  logic          start;

  assign start = reg_wr && (reg_addr == TRIG_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      fin  <= 1'b0;
      idx  <= '0;
      page <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        page <= reg_wdata;
        idx  <= '0;
      end else if (run) begin
        if (idx == LAST) begin
          run <= 1'b0;
          fin <= 1'b1;
          idx <= '0;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

  assign offs      = 8'(idx);
  assign busy      = run;
  assign done      = fin;
  assign rd_en     = run;
  assign rd_addr   = {page, offs};
  assign oam_we    = run;
  assign oam_addr  = DEST_BASE + {8'h00, offs};
  assign oam_wdata = rd_data;
endmodule

// File: rtl/oam_dma_checker.sv
module oam_dma_checker #(
  parameter int          LEN       = 160,
  parameter logic [15:0] TRIG_ADDR = 16'hFF46,
  parameter logic [15:0] DEST_BASE = 16'hFE00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [15:0] reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        rd_en,
  input logic [15:0] rd_addr,
  input logic [7:0]  rd_data,
  input logic        oam_we,
  input logic [15:0] oam_addr,
  input logic [7:0]  oam_wdata,
  input logic        busy,
  input logic        done
);
  localparam logic [7:0] LASTB = 8'(LEN - 1);
  logic trig;
  assign trig = reg_wr && (reg_addr == TRIG_ADDR);

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> busy && rd_addr == {$past(reg_wdata), 8'h00});

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trig) |=> !busy);

  a_r4_dest_offset: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> oam_addr == DEST_BASE + {8'h00, rd_addr[7:0]});

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !trig && rd_addr[7:0] != LASTB) |=> busy && rd_addr == $past(rd_addr) + 16'd1);

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !trig && rd_addr[7:0] == LASTB) |=> done && !busy);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (oam_we == busy) && (rd_en == busy));

  a_r8_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    oam_we |-> oam_wdata == rd_data);
endmodule

bind oam_dma oam_dma_checker #(.LEN(LEN), .TRIG_ADDR(TRIG_ADDR), .DEST_BASE(DEST_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .oam_we(oam_we), .oam_addr(oam_addr),
  .oam_wdata(oam_wdata), .busy(busy), .done(done)
);

// File: tb/oam_dma_test.sv
module oam_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = 16'h0000;
  logic [7:0]  reg_wdata = 8'h00;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic        oam_we;
  logic [15:0] oam_addr;
  logic [7:0]  oam_wdata;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;
  int wcount = 0;
  int stray  = 0;
  int dcount = 0;
  logic [7:0] oam [256];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] src(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd3;
    return a[15:8] ^ t ^ 8'h5A;
  endfunction

  assign rd_data = src(rd_addr);

  oam_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .oam_we(oam_we), .oam_addr(oam_addr),
    .oam_wdata(oam_wdata), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (rst_n && oam_we) begin
      if (oam_addr >= 16'hFE00 && oam_addr <= 16'hFE9F) begin
        oam[oam_addr[7:0]] <= oam_wdata;
        wcount <= wcount + 1;
      end else stray <= stray + 1;
    end
    if (rst_n && done) dcount <= dcount + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 256; i++) oam[i] = 8'h00;
    wcount = 0; stray = 0; dcount = 0;
  endtask

  task automatic poke(input logic [15:0] a, input logic [7:0] d, input logic we);
    @(negedge clk);
    reg_wr = we; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_busy_end(output int cnt);
    cnt = 0;
    while (busy && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic check_contents(input string req, input logic [7:0] page);
    int bad = 0;
    for (int i = 0; i < 160; i++)
      if (oam[i] != src({page, 8'(i)})) bad++;
    check(req, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 we in reset", int'(oam_we) + int'(rd_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
  endtask

  task automatic t_ignore();
    clear_model();
    poke(16'hFF47, 8'hC0, 1'b1);
    check("R3 other address", int'(busy), 0);
    poke(16'hFF46, 8'hC0, 1'b0);
    check("R3 strobe low", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R3 no writes", wcount + stray, 0);
  endtask

  task automatic t_copy(input logic [7:0] page);
    int cnt;
    clear_model();
    poke(16'hFF46, page, 1'b1);
    check("R2 busy after trigger", int'(busy), 1);
    check("R2 source start", int'(rd_addr), int'({page, 8'h00}));
    check("R8 rd_en follows busy", int'(rd_en), 1);
    wait_busy_end(cnt);
    check("R5 busy length", cnt, 160);
    check("R6 done after last", int'(done), 1);
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);
    check("R4 write count", wcount, 160);
    check("R4 no stray writes", stray, 0);
    check_contents("R4 contents", page);
    check("R6 done pulses", dcount, 1);
  endtask

  task automatic t_restart();
    int cnt;
    clear_model();
    poke(16'hFF46, 8'h12, 1'b1);
    repeat (49) @(negedge clk);
    poke(16'hFF46, 8'h80, 1'b1);
    check("R7 restart source", int'(rd_addr), int'(16'h8000));
    wait_busy_end(cnt);
    check("R7 restart length", cnt, 160);
    @(negedge clk);
    check("R7 total writes", wcount, 211);
    check_contents("R7 new page contents", 8'h80);
    check("R7 single done", dcount, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ignore();
        t_copy(8'h00);
        t_copy(8'hC1);
        t_copy(8'hFF);
        t_restart();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule